// File: doc/BRIEF.md
# Multiplexed-Address DRAM Row-Buffer Controller

This block models a small DRAM device together with the controller that drives it. Storage is a square array: there are as many rows as there are bits in a row. A latch row buffer sits between the array and the data port. A host issues single-word reads and writes through a valid/ready port, giving a byte address. The controller cuts the address into a row part and a column part. It opens the row in a row phase that copies the whole row into the buffer; because a behavioural DRAM read drains the cells, the array row is cleared as it is read. A column phase follows, which picks one word of the buffer: it either returns the word on the data port or replaces it inside the buffer. A restore phase then writes the full buffer back into the row.

An interval counter, programmed from a port, raises refresh requests. A refresh runs through the same row path and visits rows in ascending order. It opens each row and restores it without change. A refresh that is waiting wins the next free slot over a host request, but it never breaks into an access that has already started. Each phase lasts `PHASE` cycles and the restore lasts `2*PHASE` cycles. The access latency (row plus column) is therefore `2*PHASE`, and the spacing between two access starts is twice that.

Top module: `dram_rowbuf_ctrl`

## Requirements
- R1: The row index is `req_addr[ROW_W+COL_W+1:COL_W+2]` (bits [7:4] at defaults) and the word-within-row index is `req_addr[COL_W+1:2]` (bits [3:2]). Bits [1:0] are ignored: two addresses that differ only there reach the same word, and two addresses that differ only in row bits reach different words.
- R2: A read returns the last value written to that word. A write changes only the addressed word and leaves the other words of the same row intact.
- R3: A read is accepted on the clock edge where `req_valid` and `req_ready` are both high. `rd_valid` is then high for exactly one cycle, set by the `2*PHASE`-th edge after acceptance, with `rd_data` valid alongside it. Writes never raise `rd_valid`.
- R4: After an acceptance, `row_phase` is high for the next `PHASE` cycles and `col_phase` is high for the `PHASE` cycles after those.
- R5: `req_ready` stays low from acceptance until the operation's last restore cycle. With `req_valid` held high and no refresh due, successive acceptances are exactly `4*PHASE` cycles apart.
- R6: With the host idle and `ref_interval+1 >= 4*PHASE`, refresh operations start every `ref_interval+1` cycles. `ref_active` is high for the whole refresh operation.
- R7: Each refresh opens the row after the one the previous refresh opened (shown on `open_row`), and row `2**ROW_W-1` is followed by row 0. The first refresh after reset opens row 0.
- R8: When a refresh is pending, `req_ready` is low and the refresh takes the next free slot, even while `req_valid` is high. A refresh never starts while a host access is in its row or column phase.
- R9: Data stays intact across any number of refresh operations and host accesses to other rows, and across reset.
- R10: In the first cycle after reset, `req_ready` is 1 and `rd_valid`, `row_phase`, `col_phase` and `ref_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ref_interval | input | IVL_W | Refresh period minus one, in cycles |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W+2 | Byte address of the word |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DATA_W | Read data |
| row_phase | output | 1 | Row strobe phase active |
| col_phase | output | 1 | Column strobe phase active |
| ref_active | output | 1 | Current operation is a refresh |
| open_row | output | ROW_W | Row currently on the row path |

## Verification
The case that matters is a refresh tick and a host request both waiting for the same free slot. That slot is either the idle state or the last restore cycle. The bench sets a short refresh interval and holds `req_valid` high without a break, so the two requests meet over and over. Each time `ref_active` rises, the bench checks that in the cycle before, `req_ready` was low while `valid` was high and no row or column phase was under way. It also checks that refreshes still arrive at the tick rate and that host traffic is not starved.

// File: rtl/dram_pkg.sv
package dram_pkg;
  // Phases of one row-path operation, shared by host accesses and refresh.
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ROW     = 2'd1,
    PH_COL     = 2'd2,
    PH_RESTORE = 2'd3
  } phase_t;
endpackage

// File: rtl/dram_cell_array.sv
// Square cell array: one row per address, read-first single port so a
// block RAM can be inferred. A read issued with a write of zeros models the
// charge-draining row open.
module dram_cell_array #(
  parameter int ROW_W    = 4,
  parameter int ROW_BITS = 16
) (
  input  logic                clk,
  input  logic                we,
  input  logic [ROW_W-1:0]    addr,
  input  logic [ROW_BITS-1:0] wdata,
  output logic [ROW_BITS-1:0] rdata
);
  localparam int ROWS = 1 << ROW_W;

  logic [ROW_BITS-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    rdata <= cells[addr];
  end
endmodule

// File: rtl/dram_refresh_timer.sv
// Interval counter raising refresh requests and the walking row pointer.
module dram_refresh_timer #(
  parameter int ROW_W = 4,
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IVL_W-1:0] interval,
  input  logic             take,
  output logic             pending,
  output logic [ROW_W-1:0] row_ptr
);
  logic [IVL_W-1:0] tick_cnt;
  logic             tick;

  assign tick = (tick_cnt == interval);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt <= '0;
      pending  <= 1'b0;
      row_ptr  <= '0;
    end else begin
      tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
      if (tick)      pending <= 1'b1;
      else if (take) pending <= 1'b0;
      if (take)      row_ptr <= row_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/dram_sequencer.sv
// Row/column/restore sequencer with the latch row buffer.
module dram_sequencer
  import dram_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 2,
  parameter int DATA_W = 4,
  parameter int PHASE  = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic                             req_write,
  input  logic [ROW_W+COL_W+1:0]           req_addr,
  input  logic [DATA_W-1:0]                req_wdata,
  output logic                             rd_valid,
  output logic [DATA_W-1:0]                rd_data,
  input  logic                             ref_pending,
  input  logic [ROW_W-1:0]                 ref_row_ptr,
  output logic                             ref_take,
  output logic                             mem_we,
  output logic [ROW_W-1:0]                 mem_addr,
  output logic [(DATA_W<<COL_W)-1:0]       mem_wdata,
  input  logic [(DATA_W<<COL_W)-1:0]       mem_rdata,
  output logic                             row_phase,
  output logic                             col_phase,
  output logic                             ref_active,
  output logic [ROW_W-1:0]                 open_row
);
  localparam int ADDR_W = ROW_W + COL_W + 2;
  localparam int WORDS  = 1 << COL_W;
  localparam int CNT_W  = $clog2(2 * PHASE) + 1;
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(PHASE - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(2 * PHASE - 1);
  localparam logic [CNT_W-1:0] LOAD_AT    = CNT_W'(1);

  phase_t                        phase;
  logic [CNT_W-1:0]              cnt;
  logic                          is_ref, is_wr;
  logic [ROW_W-1:0]              row_q;
  logic [COL_W-1:0]              col_q;
  logic [DATA_W-1:0]             wdata_q;
  logic [WORDS-1:0][DATA_W-1:0]  row_buf;

  logic last, slot_free, start_ref, start_host;
  logic unused_lsbs;

  assign unused_lsbs = ^req_addr[1:0];

  always_comb begin
    if (phase == PH_RESTORE) last = (cnt == LONG_LAST);
    else                     last = (cnt == SHORT_LAST);
  end

  assign slot_free  = (phase == PH_IDLE) || (phase == PH_RESTORE && last);
  assign start_ref  = slot_free && ref_pending;
  assign req_ready  = slot_free && !ref_pending;
  assign start_host = req_ready && req_valid;
  assign ref_take   = start_ref;

  // Row open drains the row (write zeros, read-first); last restore cycle
  // puts the buffer back.
  assign mem_addr  = row_q;
  assign mem_we    = (phase == PH_ROW && cnt == '0) || (phase == PH_RESTORE && last);
  assign mem_wdata = (phase == PH_ROW) ? '0 : row_buf;

  assign row_phase  = (phase == PH_ROW);
  assign col_phase  = (phase == PH_COL);
  assign ref_active = is_ref && (phase != PH_IDLE);
  assign open_row   = row_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      is_ref   <= 1'b0;
      is_wr    <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
      wdata_q  <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (start_ref || start_host) begin
        phase   <= PH_ROW;
        cnt     <= '0;
        is_ref  <= start_ref;
        is_wr   <= req_write && !start_ref;
        row_q   <= start_ref ? ref_row_ptr : req_addr[ADDR_W-1:COL_W+2];
        col_q   <= req_addr[COL_W+1:2];
        wdata_q <= req_wdata;
      end else if (phase != PH_IDLE) begin
        if (last) begin
          cnt <= '0;
          unique case (phase)
            PH_ROW:  phase <= PH_COL;
            PH_COL:  phase <= PH_RESTORE;
            default: phase <= PH_IDLE;
          endcase
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (phase == PH_COL && last && !is_ref && !is_wr) begin
        rd_data  <= row_buf[col_q];
        rd_valid <= 1'b1;
      end
    end
  end

  // Row buffer latches: no reset needed, always loaded before use.
  always_ff @(posedge clk) begin
    if (phase == PH_ROW && cnt == LOAD_AT)
      row_buf <= mem_rdata;
    else if (phase == PH_COL && last && !is_ref && is_wr)
      row_buf[col_q] <= wdata_q;
  end
endmodule

// File: rtl/dram_rowbuf_ctrl.sv
module dram_rowbuf_ctrl #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 2,
  parameter int PHASE  = 2,
  parameter int IVL_W  = 16,
  localparam int DATA_W = (1 << ROW_W) >> COL_W,
  localparam int ADDR_W = ROW_W + COL_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IVL_W-1:0]  ref_interval,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              row_phase,
  output logic              col_phase,
  output logic              ref_active,
  output logic [ROW_W-1:0]  open_row
);
  localparam int ROW_BITS = DATA_W << COL_W;

  logic                ref_pending, ref_take;
  logic [ROW_W-1:0]    ref_row_ptr, mem_addr;
  logic                mem_we;
  logic [ROW_BITS-1:0] mem_wdata, mem_rdata;

  dram_refresh_timer #(.ROW_W(ROW_W), .IVL_W(IVL_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .interval (ref_interval),
    .take     (ref_take),
    .pending  (ref_pending),
    .row_ptr  (ref_row_ptr)
  );

  dram_cell_array #(.ROW_W(ROW_W), .ROW_BITS(ROW_BITS)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

  dram_sequencer #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .PHASE(PHASE)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .ref_pending (ref_pending),
    .ref_row_ptr (ref_row_ptr),
    .ref_take    (ref_take),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .row_phase   (row_phase),
    .col_phase   (col_phase),
    .ref_active  (ref_active),
    .open_row    (open_row)
  );
endmodule

// File: rtl/dram_rowbuf_ctrl_chk.sv
module dram_rowbuf_ctrl_chk #(
  parameter int ROW_W = 4,
  parameter int PHASE = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rd_valid,
  input logic             row_phase,
  input logic             col_phase,
  input logic             ref_active,
  input logic [ROW_W-1:0] open_row
);
  localparam int GAP_MIN = 4 * PHASE;
  localparam int GAP_W   = $clog2(GAP_MIN + 1) + 1;

  logic [GAP_W-1:0] gap;
  logic             prev_row;
  logic [ROW_W-1:0] exp_ref;
  logic             accept, ref_start;

  assign accept    = req_valid && req_ready;
  assign ref_start = row_phase && ref_active && !prev_row;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap      <= GAP_W'(GAP_MIN);
      prev_row <= 1'b0;
      exp_ref  <= '0;
    end else begin
      if (accept)                     gap <= GAP_W'(1);
      else if (gap < GAP_W'(GAP_MIN)) gap <= gap + 1'b1;
      prev_row <= row_phase;
      if (ref_start) exp_ref <= exp_ref + 1'b1;
    end
  end

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  // R3
  rd_after_col_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(col_phase) && !col_phase && !ref_active));
  // R4
  accept_row_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (row_phase && !ref_active));
  // R4
  col_follows_row_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(col_phase) |-> $past(row_phase));
  // R5
  spacing_chk: assert property (@(posedge clk) disable iff (rst)
    accept |-> (gap >= GAP_W'(GAP_MIN)));
  // R8
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    (row_phase || col_phase) |-> !req_ready);
  // R8
  no_intrude_chk: assert property (@(posedge clk) disable iff (rst)
    ((row_phase || col_phase) && !ref_active) |=> !ref_active);
  // R7
  ref_seq_chk: assert property (@(posedge clk) disable iff (rst)
    ref_start |-> (open_row == exp_ref));
endmodule

bind dram_rowbuf_ctrl dram_rowbuf_ctrl_chk #(.ROW_W(ROW_W), .PHASE(PHASE)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rd_valid   (rd_valid),
  .row_phase  (row_phase),
  .col_phase  (col_phase),
  .ref_active (ref_active),
  .open_row   (open_row)
);

// File: tb/dram_rowbuf_ctrl_test.sv
module dram_rowbuf_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int ROW_W  = 4;
  localparam int COL_W  = 2;
  localparam int PHASE  = 2;
  localparam int IVL_W  = 16;
  localparam int DATA_W = (1 << ROW_W) >> COL_W;
  localparam int ADDR_W = ROW_W + COL_W + 2;
  localparam int NWORDS = 1 << (ROW_W + COL_W);
  localparam int REF_PERIOD = 20;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [IVL_W-1:0]  ref_interval = IVL_W'(60000);
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic              row_phase, col_phase, ref_active;
  logic [ROW_W-1:0]  open_row;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] model [NWORDS];
  bit                known [NWORDS];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_rowbuf_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .PHASE(PHASE), .IVL_W(IVL_W)) uut (
    .clk(clk), .rst(rst), .ref_interval(ref_interval),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .row_phase(row_phase), .col_phase(col_phase),
    .ref_active(ref_active), .open_row(open_row)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int widx(input logic [ADDR_W-1:0] a);
    return int'(a[ADDR_W-1:2]);
  endfunction

  function automatic logic [ADDR_W-1:0] mk_addr(input int row, input int col, input int lsb);
    return ADDR_W'((row << (COL_W + 2)) | (col << 2) | lsb);
  endfunction

  function automatic int next_ref_row(input int r);
    return (r + 1) % (1 << ROW_W);
  endfunction

  // One host operation with per-cycle phase/strobe checks (R3 R4 R5).
  task automatic host_op(input bit wr, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, output logic [DATA_W-1:0] q);
    q = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    for (int k = 1; k <= 2*PHASE + 1; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      chk(row_phase == (k <= PHASE), "R4 row_phase", int'(row_phase), int'(k <= PHASE));
      chk(col_phase == (k > PHASE && k <= 2*PHASE), "R4 col_phase",
          int'(col_phase), int'(k > PHASE && k <= 2*PHASE));
      chk(rd_valid == (!wr && k == 2*PHASE + 1), "R3 rd_valid",
          int'(rd_valid), int'(!wr && k == 2*PHASE + 1));
      chk(!req_ready, "R5 ready low while busy", int'(req_ready), 0);
      if (k == 2*PHASE + 1) q = rd_data;
    end
    if (wr) begin
      model[widx(a)] = d;
      known[widx(a)] = 1'b1;
    end
  endtask

  task automatic read_expect(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp, input string tag);
    logic [DATA_W-1:0] q;
    host_op(1'b0, a, '0, q);
    chk(q == exp, tag, int'(q), int'(exp));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10
    chk(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
    chk(!rd_valid && !row_phase && !col_phase && !ref_active, "R10 idle outputs",
        int'({rd_valid, row_phase, col_phase, ref_active}), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [DATA_W-1:0] q;
    void'($urandom(32'h5eed_0d2a));
    for (int i = 0; i < NWORDS; i++) known[i] = 1'b0;

    do_reset();

    // Directed: row 3, all four words.
    host_op(1'b1, mk_addr(3, 0, 0), 4'h5, q);
    host_op(1'b1, mk_addr(3, 1, 0), 4'hA, q);
    host_op(1'b1, mk_addr(3, 2, 0), 4'h3, q);
    host_op(1'b1, mk_addr(3, 3, 0), 4'hC, q);
    read_expect(mk_addr(3, 1, 3), 4'hA, "R1 low bits ignored on read");
    read_expect(mk_addr(3, 0, 0), 4'h5, "R2 read back");
    host_op(1'b1, mk_addr(3, 1, 1), 4'h6, q);
    read_expect(mk_addr(3, 0, 0), 4'h5, "R2 neighbour word 0 intact");
    read_expect(mk_addr(3, 2, 2), 4'h3, "R2 neighbour word 2 intact");
    read_expect(mk_addr(3, 3, 0), 4'hC, "R2 neighbour word 3 intact");
    read_expect(mk_addr(3, 1, 0), 4'h6, "R1 low bits ignored on write");
    host_op(1'b1, mk_addr(4, 1, 0), 4'h9, q);
    read_expect(mk_addr(3, 1, 0), 4'h6, "R1 row bits select distinct row");
    read_expect(mk_addr(4, 1, 0), 4'h9, "R1 other row holds own data");

    // Constrained random traffic against the model.
    for (int n = 0; n < 300; n++) begin
      bit wr;
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
      wr = ($urandom % 3) != 0;
      a  = ADDR_W'($urandom);
      d  = DATA_W'($urandom);
      if (wr) host_op(1'b1, a, d, q);
      else if (known[widx(a)]) read_expect(a, model[widx(a)], "R2 random read");
    end

    // Back-to-back spacing with valid held (R5).
    begin
      int last_t = -1;
      int n_acc = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = mk_addr(3, 1, 0);
      for (int t = 0; t < 60; t++) begin
        if (req_ready) begin
          if (last_t >= 0)
            chk(t - last_t == 4*PHASE, "R5 back-to-back spacing", t - last_t, 4*PHASE);
          last_t = t;
          n_acc++;
        end
        @(negedge clk);
      end
      req_valid = 1'b0;
      chk(n_acc >= 7, "R5 accept count", n_acc, 7);
      repeat (4*PHASE) @(negedge clk);
    end

    // Refresh walker with idle host (R6 R7).
    ref_interval = IVL_W'(REF_PERIOD - 1);
    do_reset();
    begin
      int prev_t = -1;
      int prev_row = -1;
      int nrise = 0;
      bit prev_ref = 1'b0;
      for (int t = 0; t < 460 && nrise < 20; t++) begin
        if (ref_active && !prev_ref) begin
          if (nrise == 0) begin
            chk(open_row == '0, "R7 first refresh row", int'(open_row), 0);
          end else begin
            chk(t - prev_t == REF_PERIOD, "R6 refresh spacing", t - prev_t, REF_PERIOD);
            chk(int'(open_row) == next_ref_row(prev_row), "R7 refresh row order",
                int'(open_row), next_ref_row(prev_row));
          end
          prev_t = t;
          prev_row = int'(open_row);
          nrise++;
        end
        prev_ref = ref_active;
        @(negedge clk);
      end
      chk(nrise == 20, "R6 refresh count", nrise, 20);
    end

    // Data retention across reset and refresh (R9).
    for (int w = 0; w < NWORDS; w++)
      if (known[w]) read_expect(ADDR_W'(w << 2), model[w], "R9 retained after refresh");

    // Refresh tick against continuous host demand (R8).
    begin
      bit prev_ready = 1'b0, prev_valid = 1'b0, prev_busy = 1'b0, prev_ref;
      int nref = 0, nacc = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = mk_addr(4, 1, 0);
      prev_ref = ref_active;
      for (int t = 0; t < 400; t++) begin
        @(negedge clk);
        if (ref_active && !prev_ref) begin
          nref++;
          chk(prev_valid && !prev_ready && !prev_busy, "R8 refresh wins free slot",
              int'({prev_valid, prev_ready, prev_busy}), 4);
        end
        if (req_ready) nacc++;
        prev_ready = req_ready;
        prev_valid = req_valid;
        prev_busy  = row_phase || col_phase;
        prev_ref   = ref_active;
      end
      req_valid = 1'b0;
      chk(nref >= 18, "R8 refresh not starved", nref, 18);
      chk(nacc >= 20, "R8 host not starved", nacc, 20);
      repeat (4*PHASE) @(negedge clk);
    end
    read_expect(mk_addr(4, 1, 0), 4'h9, "R9 retained after contention");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule